// File: doc/BRIEF.md
# Integer Execute Unit with HI/LO Pair

This block is the integer execute stage of a 32-bit load/store core. Each cycle it takes an operation code, two 32-bit operands (called S and T), a 5-bit immediate shift count and an issue strobe. It then produces a result word, a destination write-enable, a signed-overflow trap flag and an illegal-operation flag. All of these outputs are combinational.

The block also holds the HI and LO special registers. A move-to instruction writes them at the clock edge, but only while the issue strobe is high. A move-from instruction reads them back onto the result.

The unit supports the following operations:

- Shifts, with the count taken either from the immediate field or from S.
- Zero and non-zero conditional moves.
- Add and subtract, each in a trapping and a wrapping form.
- The four bitwise operations.
- Signed and unsigned set-less-than.

Top module: `int_exec_unit`

## Requirements
- R1: After a synchronous active-low reset, both HI and LO read back as 0.
- R2: Opcodes 0, 1 and 2 shift T left, right logically or right arithmetically by `shamt_i`. For example, 0x80000001 left by 3 gives 0x8, and 0x80000008 right by 3 gives 0x10000001 (logical) or 0xF0000001 (arithmetic). A shift never raises the trap.
- R3: Opcodes 3, 4 and 5 shift T in the same three ways, but the count is the low 5 bits of S, and `shamt_i` is ignored.
- R4: Opcode 6 returns S with write-enable 1 when T is zero. Opcode 7 does the same when T is non-zero. When the condition fails, write-enable is 0 and the result is 0.
- R5: Opcodes 8 and 9 return HI and LO without changing them. Opcodes 10 and 11 load S into HI or LO respectively on an issued cycle, and leave the other register alone. Their result is 0 and their write-enable is 0.
- R6: Opcodes 12 (add) and 14 (subtract, S−T) raise `ovf_trap_o` on signed overflow. On a trap, the result is 0 and write-enable is 0.
- R7: Opcodes 13 (add) and 15 (subtract) wrap modulo 2^32 and never trap. For example, 24−66 gives 0xFFFFFFD6.
- R8: Opcodes 16, 17, 18 and 19 give S AND T, S OR T, S XOR T and NOR(S, T).
- R9: Opcode 20 returns 1 when S < T as signed values, and opcode 21 returns 1 when S < T as unsigned values. Otherwise both return 0.
- R10: Opcodes 22 to 31 raise `bad_op_o` and force the result to 0 and write-enable to 0. HI and LO keep their values even when such an opcode is issued.
- R11: On a cycle without issue, HI and LO keep their values whatever the opcode is.
- R12: Every legal opcode other than 6, 7, 10 and 11 drives write-enable 1, unless it traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Instruction is committed this cycle (gates HI/LO writes) |
| op_i | input | 5 | Operation code |
| opnd_s_i | input | 32 | Operand S |
| opnd_t_i | input | 32 | Operand T |
| shamt_i | input | 5 | Immediate shift count |
| result_o | output | 32 | Result word |
| wr_en_o | output | 1 | Destination write-enable |
| ovf_trap_o | output | 1 | Signed overflow trap |
| bad_op_o | output | 1 | Unsupported opcode |

## Verification
The hardest state to reach from the ports is the HI/LO pair after a write that should have been blocked. Such writes are an un-issued move-to, or an issued illegal opcode carrying a fresh S. The pair has no output of its own, so it is only visible through a later read operation.

The bench therefore loads distinct known values into HI and LO on issued cycles. It then presents each blocking case for a full clock edge. Afterwards it reads both registers back, which shows whether either word moved. Overflow cases use operands on both sides of the sign boundary, so that the trapping and wrapping forms are driven with identical operands and their flags and results can be compared.

// File: rtl/iexu_pkg.sv
// Package iexu_pkg
// Shared opcode and shift-mode encodings for the integer execute unit.
// Assumes a 5-bit opcode space; codes above OP_LT_U are illegal.
package iexu_pkg;

    typedef enum logic [4:0] {
        OP_SHL_IMM = 5'd0,
        OP_SHR_IMM = 5'd1,
        OP_SAR_IMM = 5'd2,
        OP_SHL_VAR = 5'd3,
        OP_SHR_VAR = 5'd4,
        OP_SAR_VAR = 5'd5,
        OP_MOV_Z   = 5'd6,
        OP_MOV_NZ  = 5'd7,
        OP_RD_HI   = 5'd8,
        OP_RD_LO   = 5'd9,
        OP_WR_HI   = 5'd10,
        OP_WR_LO   = 5'd11,
        OP_ADD_T   = 5'd12,
        OP_ADD_W   = 5'd13,
        OP_SUB_T   = 5'd14,
        OP_SUB_W   = 5'd15,
        OP_AND     = 5'd16,
        OP_OR      = 5'd17,
        OP_XOR     = 5'd18,
        OP_NOR     = 5'd19,
        OP_LT_S    = 5'd20,
        OP_LT_U    = 5'd21
    } iexu_op_e;

    localparam logic [4:0] OP_LAST_LEGAL = 5'd21;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } iexu_shmode_e;

endpackage

// File: rtl/iexu_shifter.sv
// Module iexu_shifter
// Logarithmic barrel shifter for left, logical-right and arithmetic-right.
// A left shift reverses the word, shifts right with zero fill and then
// reverses back, so only one right-shifting stage chain is built.
// Assumes DATA_W is a power of two.
module iexu_shifter
    import iexu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  iexu_shmode_e       mode_i,
    input  logic [AMT_W-1:0]   amt_i,
    input  logic [DATA_W-1:0]  val_i,
    output logic [DATA_W-1:0]  val_o
);

    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] post;
    logic              fill;
    logic [DATA_W-1:0] stg [0:AMT_W];

    // Reverse the input bit order for left shifts.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            pre[i] = (mode_i == SH_LEFT) ? val_i[DATA_W-1-i] : val_i[i];
        end
    end

    // The fill bit is the sign bit only for arithmetic shifts.
    always_comb fill = (mode_i == SH_RARI) ? val_i[DATA_W-1] : 1'b0;

    assign stg[0] = pre;

    // One stage per count bit, each shifting by a power of two.
    generate
        for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stg[k+1] = amt_i[k] ? {{SH{fill}}, stg[k][DATA_W-1:SH]}
                                       : stg[k];
        end
    endgenerate

    assign post = stg[AMT_W];

    // Undo the reversal for left shifts.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            val_o[i] = (mode_i == SH_LEFT) ? post[DATA_W-1-i] : post[i];
        end
    end

endmodule

// File: rtl/iexu_addsub.sv
// Module iexu_addsub
// Adder and subtractor with signed-overflow detection, plus signed and
// unsigned less-than comparisons.
// Assumes two's-complement operands; the subtraction is a - b.
module iexu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] diff_o,
    output logic              add_ovf_o,
    output logic              sub_ovf_o,
    output logic              lt_s_o,
    output logic              lt_u_o
);

    localparam int MSB = DATA_W - 1;

    // Wrapping sum and difference.
    always_comb begin
        sum_o  = a_i + b_i;
        diff_o = a_i - b_i;
    end

    // Overflow: same-sign addends give a different-sign sum; for subtraction,
    // opposite-sign operands give a result whose sign differs from a.
    always_comb begin
        add_ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB]  != a_i[MSB]);
        sub_ovf_o = (a_i[MSB] != b_i[MSB]) && (diff_o[MSB] != a_i[MSB]);
    end

    // Comparisons in both number systems.
    always_comb begin
        lt_s_o = $signed(a_i) < $signed(b_i);
        lt_u_o = a_i < b_i;
    end

endmodule

// File: rtl/iexu_hilo.sv
// Module iexu_hilo
// HI/LO special register pair with independent write strobes.
// Assumes the strobes are already qualified by issue and opcode.
module iexu_hilo #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0] lo_o
);

    // HI register: cleared on reset, loaded on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_o <= '0;
        else if (wr_hi_i) hi_o <= din_i;
    end

    // LO register: cleared on reset, loaded on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_o <= '0;
        else if (wr_lo_i) lo_o <= din_i;
    end

endmodule

// File: rtl/int_exec_unit.sv
// Module int_exec_unit
// Integer execute unit: decodes the opcode, steers the operands to the
// shifter, adder and logic, and selects the result.
// On a trap or an illegal opcode, result and write-enable are forced to 0.
// HI/LO writes happen only on issued move-to opcodes.
// Assumes the operands are stable for the whole cycle.
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_i,
    input  logic [4:0]         op_i,
    input  logic [DATA_W-1:0]  opnd_s_i,
    input  logic [DATA_W-1:0]  opnd_t_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               wr_en_o,
    output logic               ovf_trap_o,
    output logic               bad_op_o
);

    iexu_shmode_e       sh_mode;
    logic [SHAMT_W-1:0] sh_amt;
    logic [DATA_W-1:0]  sh_out;
    logic [DATA_W-1:0]  sum, diff;
    logic               add_ovf, sub_ovf, lt_s, lt_u;
    logic [DATA_W-1:0]  hi_val, lo_val;
    logic               wr_hi, wr_lo;
    logic               t_zero;
    logic [DATA_W-1:0]  res_raw;
    logic               wen_raw;

    // Shifter mode and count selection from the opcode.
    always_comb begin
        unique case (op_i)
            OP_SHR_IMM, OP_SHR_VAR: sh_mode = SH_RLOG;
            OP_SAR_IMM, OP_SAR_VAR: sh_mode = SH_RARI;
            default:                sh_mode = SH_LEFT;
        endcase
        if (op_i == OP_SHL_VAR || op_i == OP_SHR_VAR || op_i == OP_SAR_VAR)
            sh_amt = opnd_s_i[SHAMT_W-1:0];
        else
            sh_amt = shamt_i;
    end

    iexu_shifter #(.DATA_W(DATA_W)) u_shift (
        .mode_i (sh_mode),
        .amt_i  (sh_amt),
        .val_i  (opnd_t_i),
        .val_o  (sh_out)
    );

    iexu_addsub #(.DATA_W(DATA_W)) u_arith (
        .a_i       (opnd_s_i),
        .b_i       (opnd_t_i),
        .sum_o     (sum),
        .diff_o    (diff),
        .add_ovf_o (add_ovf),
        .sub_ovf_o (sub_ovf),
        .lt_s_o    (lt_s),
        .lt_u_o    (lt_u)
    );

    // Issued move-to opcodes become register write strobes.
    always_comb begin
        wr_hi = issue_i && (op_i == OP_WR_HI);
        wr_lo = issue_i && (op_i == OP_WR_LO);
    end

    iexu_hilo #(.DATA_W(DATA_W)) u_hilo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi_i (wr_hi),
        .wr_lo_i (wr_lo),
        .din_i   (opnd_s_i),
        .hi_o    (hi_val),
        .lo_o    (lo_val)
    );

    // Zero detect for the conditional moves.
    always_comb t_zero = (opnd_t_i == '0);

    // Raw result, write-enable, trap and illegal flag per opcode.
    always_comb begin
        res_raw    = '0;
        wen_raw    = 1'b1;
        ovf_trap_o = 1'b0;
        bad_op_o   = 1'b0;
        unique case (op_i)
            OP_SHL_IMM, OP_SHR_IMM, OP_SAR_IMM,
            OP_SHL_VAR, OP_SHR_VAR, OP_SAR_VAR: res_raw = sh_out;
            OP_MOV_Z: begin
                wen_raw = t_zero;
                res_raw = t_zero ? opnd_s_i : '0;
            end
            OP_MOV_NZ: begin
                wen_raw = !t_zero;
                res_raw = t_zero ? '0 : opnd_s_i;
            end
            OP_RD_HI: res_raw = hi_val;
            OP_RD_LO: res_raw = lo_val;
            OP_WR_HI, OP_WR_LO: wen_raw = 1'b0;
            OP_ADD_T: begin
                res_raw    = sum;
                ovf_trap_o = add_ovf;
            end
            OP_ADD_W: res_raw = sum;
            OP_SUB_T: begin
                res_raw    = diff;
                ovf_trap_o = sub_ovf;
            end
            OP_SUB_W: res_raw = diff;
            OP_AND:   res_raw = opnd_s_i & opnd_t_i;
            OP_OR:    res_raw = opnd_s_i | opnd_t_i;
            OP_XOR:   res_raw = opnd_s_i ^ opnd_t_i;
            OP_NOR:   res_raw = ~(opnd_s_i | opnd_t_i);
            OP_LT_S:  res_raw = {{(DATA_W-1){1'b0}}, lt_s};
            OP_LT_U:  res_raw = {{(DATA_W-1){1'b0}}, lt_u};
            default: begin
                bad_op_o = 1'b1;
                wen_raw  = 1'b0;
            end
        endcase
    end

    // Squash the result and write-enable on a trap or an illegal opcode.
    always_comb begin
        if (ovf_trap_o || bad_op_o) begin
            result_o = '0;
            wr_en_o  = 1'b0;
        end else begin
            result_o = res_raw;
            wr_en_o  = wen_raw;
        end
    end

endmodule

// File: rtl/iexu_checker.sv
// Module iexu_checker
// Property checks for int_exec_unit, attached with bind.
module iexu_checker
    import iexu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [4:0]        op_i,
    input logic [DATA_W-1:0] opnd_s_i,
    input logic [DATA_W-1:0] opnd_t_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic              ovf_trap_o,
    input logic              bad_op_o,
    input logic [DATA_W-1:0] hi_q,
    input logic [DATA_W-1:0] lo_q
);

    // R2: a shift never traps.
    p_shift_no_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= OP_SAR_VAR) |-> !ovf_trap_o);

    // R4: a failed zero-move does not write.
    p_movz_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MOV_Z && opnd_t_i != '0) |-> !wr_en_o);

    // R5: an issued move-to-HI loads S into HI.
    p_hi_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == OP_WR_HI) |=> (hi_q == $past(opnd_s_i)));

    // R6: a trap squashes the result and the write.
    p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o |-> (result_o == '0 && !wr_en_o));

    // R7: the wrapping add and subtract never trap.
    p_wrap_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD_W || op_i == OP_SUB_W) |-> !ovf_trap_o);

    // R10: an illegal opcode squashes the result and the write.
    p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op_o |-> (result_o == '0 && !wr_en_o));

    // R11: without issue, HI and LO keep their values.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind int_exec_unit iexu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .op_i       (op_i),
    .opnd_s_i   (opnd_s_i),
    .opnd_t_i   (opnd_t_i),
    .result_o   (result_o),
    .wr_en_o    (wr_en_o),
    .ovf_trap_o (ovf_trap_o),
    .bad_op_o   (bad_op_o),
    .hi_q       (hi_val),
    .lo_q       (lo_val)
);

// File: tb/int_exec_unit_test.sv
// Directed bench for int_exec_unit: one task per scenario.
module int_exec_unit_test;
    import iexu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [4:0]  op = 5'd0;
    logic [31:0] s = '0, t = '0;
    logic [4:0]  sa = '0;
    logic [31:0] res;
    logic        wen, trap, bad;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    int_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_i(op),
        .opnd_s_i(s), .opnd_t_i(t), .shamt_i(sa),
        .result_o(res), .wr_en_o(wen), .ovf_trap_o(trap), .bad_op_o(bad)
    );

    // Compare one observed value against its expected value.
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one operation at the falling edge, then settle.
    task automatic drive(input logic [4:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] amt,
                         input logic iss);
        @(negedge clk);
        op = o; s = a; t = b; sa = amt; issue = iss;
        #2;
    endtask

    // Drive an operation and check result, write-enable and both flags.
    task automatic op_chk(input string req, input logic [4:0] o,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] amt, input logic [31:0] e_res,
                          input logic e_wen, input logic e_trap,
                          input logic e_bad);
        drive(o, a, b, amt, 1'b0);
        chk(req, "result", res, e_res);
        chk(req, "wr_en", {31'd0, wen}, {31'd0, e_wen});
        chk(req, "trap", {31'd0, trap}, {31'd0, e_trap});
        chk(req, "bad_op", {31'd0, bad}, {31'd0, e_bad});
    endtask

    // Read HI and LO through the read opcodes.
    task automatic read_hilo(input string req, input logic [31:0] e_hi,
                             input logic [31:0] e_lo);
        op_chk(req, OP_RD_HI, 32'h0, 32'h0, 5'd0, e_hi, 1'b1, 1'b0, 1'b0);
        op_chk(req, OP_RD_LO, 32'h0, 32'h0, 5'd0, e_lo, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_reset;  // R1
        read_hilo("R1", 32'h0, 32'h0);
    endtask

    task automatic t_imm_shift;  // R2
        op_chk("R2", OP_SHL_IMM, 32'h0, 32'h80000001, 5'd3, 32'h8, 1, 0, 0);
        op_chk("R2", OP_SHR_IMM, 32'h0, 32'h80000008, 5'd3, 32'h10000001, 1, 0, 0);
        op_chk("R2", OP_SAR_IMM, 32'h0, 32'h80000008, 5'd3, 32'hF0000001, 1, 0, 0);
        op_chk("R2", OP_SAR_IMM, 32'h7, 32'h80000000, 5'd31, 32'hFFFFFFFF, 1, 0, 0);
        op_chk("R2", OP_SHL_IMM, 32'h9, 32'h12345678, 5'd0, 32'h12345678, 1, 0, 0);
    endtask

    task automatic t_var_shift;  // R3
        op_chk("R3", OP_SHL_VAR, 32'h3, 32'h80000001, 5'd7, 32'h8, 1, 0, 0);
        op_chk("R3", OP_SHR_VAR, 32'h23, 32'h80000008, 5'd0, 32'h10000001, 1, 0, 0);
        op_chk("R3", OP_SAR_VAR, 32'hFFFFFFE3, 32'h80000008, 5'd1, 32'hF0000001, 1, 0, 0);
    endtask

    task automatic t_cmov;  // R4
        op_chk("R4", OP_MOV_Z,  32'd22, 32'd0, 5'd0, 32'd22, 1, 0, 0);
        op_chk("R4", OP_MOV_Z,  32'd22, 32'd5, 5'd0, 32'd0, 0, 0, 0);
        op_chk("R4", OP_MOV_NZ, 32'd22, 32'd1, 5'd0, 32'd22, 1, 0, 0);
        op_chk("R4", OP_MOV_NZ, 32'd22, 32'd0, 5'd0, 32'd0, 0, 0, 0);
    endtask

    task automatic t_hilo;  // R5
        drive(OP_WR_HI, 32'd42, 32'd0, 5'd0, 1'b1);
        chk("R5", "wr result", res, 32'h0);
        chk("R5", "wr wr_en", {31'd0, wen}, 32'h0);
        drive(OP_WR_LO, 32'd24, 32'd0, 5'd0, 1'b1);
        read_hilo("R5", 32'd42, 32'd24);
        drive(OP_WR_HI, 32'd43, 32'd0, 5'd0, 1'b1);
        read_hilo("R5", 32'd43, 32'd24);
        drive(OP_WR_LO, 32'd23, 32'd0, 5'd0, 1'b1);
        read_hilo("R5", 32'd43, 32'd23);
    endtask

    task automatic t_trap_arith;  // R6 and R12
        op_chk("R6", OP_ADD_T, 32'h8FFFFFFF, 32'h90000000, 5'd0, 32'h0, 0, 1, 0);
        op_chk("R6", OP_ADD_T, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h0, 0, 1, 0);
        op_chk("R6", OP_SUB_T, 32'h80000000, 32'h1, 5'd0, 32'h0, 0, 1, 0);
        op_chk("R12", OP_ADD_T, 32'd24, 32'd66, 5'd0, 32'd90, 1, 0, 0);
        op_chk("R12", OP_SUB_T, 32'd66, 32'd24, 5'd0, 32'd42, 1, 0, 0);
        op_chk("R6", OP_SUB_T, 32'd3, 32'd4, 5'd0, 32'hFFFFFFFF, 1, 0, 0);
    endtask

    task automatic t_wrap_arith;  // R7
        op_chk("R7", OP_ADD_W, 32'h8FFFFFFF, 32'h90000000, 5'd0, 32'h1FFFFFFF, 1, 0, 0);
        op_chk("R7", OP_SUB_W, 32'd24, 32'd66, 5'd0, 32'hFFFFFFD6, 1, 0, 0);
        op_chk("R7", OP_SUB_W, 32'h80000000, 32'h1, 5'd0, 32'h7FFFFFFF, 1, 0, 0);
    endtask

    task automatic t_logic;  // R8
        op_chk("R8", OP_AND, 32'hA81, 32'h603, 5'd0, 32'h201, 1, 0, 0);
        op_chk("R8", OP_OR,  32'hA81, 32'h603, 5'd0, 32'hE83, 1, 0, 0);
        op_chk("R8", OP_XOR, 32'hA81, 32'h603, 5'd0, 32'hC82, 1, 0, 0);
        op_chk("R8", OP_NOR, 32'hA81, 32'h603, 5'd0, 32'hFFFFF17C, 1, 0, 0);
    endtask

    task automatic t_compare;  // R9
        op_chk("R9", OP_LT_S, 32'hFFFFFFE1, 32'd24, 5'd0, 32'd1, 1, 0, 0);
        op_chk("R9", OP_LT_U, 32'hFFFFFFE1, 32'd24, 5'd0, 32'd0, 1, 0, 0);
        op_chk("R9", OP_LT_U, 32'd24, 32'd32, 5'd0, 32'd1, 1, 0, 0);
        op_chk("R9", OP_LT_S, 32'd7, 32'd7, 5'd0, 32'd0, 1, 0, 0);
    endtask

    task automatic t_illegal;  // R10
        op_chk("R10", 5'd22, 32'd5, 32'd6, 5'd0, 32'h0, 0, 0, 1);
        op_chk("R10", 5'd31, 32'hFFFFFFFF, 32'h1, 5'd3, 32'h0, 0, 0, 1);
        drive(5'd26, 32'd99, 32'd0, 5'd0, 1'b1);
        chk("R10", "bad_op issued", {31'd0, bad}, 32'd1);
        read_hilo("R10", 32'd43, 32'd23);
    endtask

    task automatic t_no_issue;  // R11
        drive(OP_WR_HI, 32'd777, 32'd0, 5'd0, 1'b0);
        drive(OP_WR_LO, 32'd888, 32'd0, 5'd0, 1'b0);
        read_hilo("R11", 32'd43, 32'd23);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_imm_shift();
        t_var_shift();
        t_cmov();
        t_hilo();
        t_trap_arith();
        t_wrap_arith();
        t_logic();
        t_compare();
        t_illegal();
        t_no_issue();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule